// File: doc/BRIEF.md
# Shared PWM Generator Bank

This block holds eight waveform generators and lets 33 output pins share them. Sixteen pins drive outputs directly. The other seventeen form a vector that a separate serial LED chain consumes. Each generator has three 8-bit settings: a period multiplier, a high count and a low count. One waveform cycle is made of high+low steps. Each step lasts "period" pulses of the external tick enable. The output is high during the first "high" steps and low during the rest.

Software programs the block through a single-cycle write port (word address, 32-bit data, write strobe). It also decides which generator serves which pin, because several pins may share one generator. Each pin has a 4-bit map entry that enables the pin and selects a generator. Changes to a generator's settings are staged. A running generator picks up the new settings only when its current cycle ends, so no cycle is ever cut short. Map changes act at once.

Top module: `pwm_gen_bank`

## Requirements
- R1: After a synchronous reset, all periods, duty counts and map entries are zero, so every pin reads low. Pins stay low while ticks arrive until software writes a configuration.
- R2: Period words sit at word addresses 0 and 1. Generator g uses address g/4, bits [8*(g%4)+7 : 8*(g%4)].
- R3: Duty words sit at addresses 2 to 5. Generator g uses address 2+g/2. Its high count is at bits [16*(g%2)+7 : 16*(g%2)] and its low count is at bits [16*(g%2)+15 : 16*(g%2)+8].
- R4: Direct pin p maps through address 6+p/8. Serial pin s maps through address 8+s/8. Each pin's nibble is at bits [4*(n%8)+3 : 4*(n%8)]: bit 3 enables the pin and bits 2:0 give the generator id.
- R5: A running generator with period P, high count H and low count L drives high for H*P tick pulses, then low for L*P tick pulses, and repeats.
- R6: High count 255 with low count 0 keeps the output high without a gap across cycle boundaries.
- R7: High count 0 keeps the output low.
- R8: A period of 0 stops the generator, and its output is low. A stopped generator takes new settings in the clock after they are written. It then starts a cycle with the high phase.
- R9: New settings written to a running generator take effect only at the end of the cycle in progress. The rest of that cycle runs with the old counts.
- R10: A pin whose enable bit is clear reads low whatever its generator id. An enabled pin follows its selected generator, and any number of pins may select the same generator.
- R11: Writes to word addresses 11 to 15 change no setting and no output.
- R12: A map write changes the pin output in the next clock, without waiting for a cycle boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Base time-unit pulse, one clock wide |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 32 | Write data |
| dir_pins_o | output | NUM_DIRECT | Direct pin outputs |
| ser_pins_o | output | NUM_SERIAL | Pin outputs for the serial LED chain |

## Verification
The bench builds the block with its default parameters: 16 direct pins, 17 serial pins and a 4-bit word address. With these values the last serial map word, which holds only one live entry, can be reached. So can the five unmapped addresses at the top of the space. Generators are picked so that the lower and upper halves of duty words and different bytes of period words are all exercised. One run slows the tick to one pulse in three clocks, which shows that run lengths scale with the tick rate.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    localparam int NUM_GEN       = 8;
    localparam int GEN_ID_W      = $clog2(NUM_GEN);
    localparam int CNT_W         = 8;
    localparam int WORD_W        = 32;
    localparam int PER_PER_WORD  = WORD_W / CNT_W;        // 4 period fields per word
    localparam int DUTY_PER_WORD = WORD_W / (2 * CNT_W);  // 2 generators per duty word
    localparam int ENTRY_W       = GEN_ID_W + 1;
    localparam int PINS_PER_WORD = WORD_W / ENTRY_W;      // 8 map entries per word

    typedef struct packed {
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] high;
        logic [CNT_W-1:0] low;
    } gen_cfg_t;

    typedef struct packed {
        logic                en;
        logic [GEN_ID_W-1:0] id;
    } pin_map_t;

    function automatic int words_for(input int items, input int per_word);
        return (items + per_word - 1) / per_word;
    endfunction

endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
    import pwm_bank_pkg::*;
#(
    parameter int NUM_DIRECT = 16,
    parameter int NUM_SERIAL = 17,
    parameter int ADDR_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output gen_cfg_t          gen_cfg_o [NUM_GEN],
    output pin_map_t          dir_map_o [NUM_DIRECT],
    output pin_map_t          ser_map_o [NUM_SERIAL]
);

    localparam int PER_BASE  = 0;
    localparam int DUTY_BASE = PER_BASE + words_for(NUM_GEN, PER_PER_WORD);
    localparam int DIR_BASE  = DUTY_BASE + words_for(NUM_GEN, DUTY_PER_WORD);
    localparam int SER_BASE  = DIR_BASE + words_for(NUM_DIRECT, PINS_PER_WORD);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int g = 0; g < NUM_GEN; g++) gen_cfg_o[g] <= '0;
            for (int p = 0; p < NUM_DIRECT; p++) dir_map_o[p] <= '0;
            for (int s = 0; s < NUM_SERIAL; s++) ser_map_o[s] <= '0;
        end else if (wr_en) begin
            for (int g = 0; g < NUM_GEN; g++) begin
                if (wr_addr == ADDR_W'(PER_BASE + g / PER_PER_WORD))
                    gen_cfg_o[g].period <= wr_data[CNT_W*(g%PER_PER_WORD) +: CNT_W];
                if (wr_addr == ADDR_W'(DUTY_BASE + g / DUTY_PER_WORD)) begin
                    gen_cfg_o[g].high <= wr_data[2*CNT_W*(g%DUTY_PER_WORD) +: CNT_W];
                    gen_cfg_o[g].low  <= wr_data[2*CNT_W*(g%DUTY_PER_WORD)+CNT_W +: CNT_W];
                end
            end
            for (int p = 0; p < NUM_DIRECT; p++)
                if (wr_addr == ADDR_W'(DIR_BASE + p / PINS_PER_WORD))
                    dir_map_o[p] <= wr_data[ENTRY_W*(p%PINS_PER_WORD) +: ENTRY_W];
            for (int s = 0; s < NUM_SERIAL; s++)
                if (wr_addr == ADDR_W'(SER_BASE + s / PINS_PER_WORD))
                    ser_map_o[s] <= wr_data[ENTRY_W*(s%PINS_PER_WORD) +: ENTRY_W];
        end
    end

endmodule

// File: rtl/pwm_wave_gen.sv
module pwm_wave_gen
    import pwm_bank_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick_en,
    input  gen_cfg_t cfg_i,
    output logic     wave_o
);

    localparam int STEP_W = CNT_W + 1;

    gen_cfg_t          act;
    logic [CNT_W-1:0]  sub_cnt;
    logic [STEP_W-1:0] step_cnt;
    logic [STEP_W-1:0] total;
    logic              running, last_sub, last_step, boundary;

    always_comb begin
        total     = {1'b0, act.high} + {1'b0, act.low};
        running   = act.period != '0;
        last_sub  = sub_cnt == act.period - CNT_W'(1);
        last_step = (total == '0) || (step_cnt == total - STEP_W'(1));
        boundary  = running && tick_en && last_sub && last_step;
        wave_o    = running && (step_cnt < {1'b0, act.high});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act      <= '0;
            sub_cnt  <= '0;
            step_cnt <= '0;
        end else if (!running) begin
            act      <= cfg_i;
            sub_cnt  <= '0;
            step_cnt <= '0;
        end else if (tick_en) begin
            if (last_sub) begin
                sub_cnt <= '0;
                if (last_step) begin
                    step_cnt <= '0;
                    act      <= cfg_i;
                end else begin
                    step_cnt <= step_cnt + STEP_W'(1);
                end
            end else begin
                sub_cnt <= sub_cnt + CNT_W'(1);
            end
        end
    end

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (running && !boundary) |=> $stable(act));

    // R5
    sub_range_chk: assert property (@(posedge clk) disable iff (rst)
        running |-> (sub_cnt < act.period));

    // R5
    step_range_chk: assert property (@(posedge clk) disable iff (rst)
        (running && total != '0) |-> (step_cnt < total));

    // R6
    full_on_chk: assert property (@(posedge clk) disable iff (rst)
        (running && act.high == '1 && act.low == '0) |-> wave_o);

    // R8
    stop_low_chk: assert property (@(posedge clk) disable iff (rst)
        (boundary && cfg_i.period == '0) |=> !wave_o);

endmodule

// File: rtl/pwm_pin_mux.sv
module pwm_pin_mux
    import pwm_bank_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  pin_map_t             map_i [NUM_PINS],
    input  logic [NUM_GEN-1:0]   waves_i,
    output logic [NUM_PINS-1:0]  pins_o
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assign pins_o[p] = map_i[p].en & waves_i[map_i[p].id];
    end

endmodule

// File: rtl/pwm_gen_bank.sv
module pwm_gen_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_DIRECT = 16,
    parameter int NUM_SERIAL = 17,
    parameter int ADDR_W     = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick_en,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [31:0]           wr_data,
    output logic [NUM_DIRECT-1:0] dir_pins_o,
    output logic [NUM_SERIAL-1:0] ser_pins_o
);

    gen_cfg_t           gen_cfg [NUM_GEN];
    pin_map_t           dir_map [NUM_DIRECT];
    pin_map_t           ser_map [NUM_SERIAL];
    logic [NUM_GEN-1:0] waves;

    pwm_cfg_regs #(
        .NUM_DIRECT(NUM_DIRECT),
        .NUM_SERIAL(NUM_SERIAL),
        .ADDR_W    (ADDR_W)
    ) regs_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .gen_cfg_o(gen_cfg),
        .dir_map_o(dir_map),
        .ser_map_o(ser_map)
    );

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        pwm_wave_gen gen_i (
            .clk    (clk),
            .rst    (rst),
            .tick_en(tick_en),
            .cfg_i  (gen_cfg[g]),
            .wave_o (waves[g])
        );
    end

    pwm_pin_mux #(.NUM_PINS(NUM_DIRECT)) dir_mux_i (
        .map_i  (dir_map),
        .waves_i(waves),
        .pins_o (dir_pins_o)
    );

    pwm_pin_mux #(.NUM_PINS(NUM_SERIAL)) ser_mux_i (
        .map_i  (ser_map),
        .waves_i(waves),
        .pins_o (ser_pins_o)
    );

endmodule

// File: tb/pwm_gen_bank_tb_top.sv
module pwm_gen_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [15:0] dir_pins_o;
    logic [16:0] ser_pins_o;

    int n_checks = 0;
    int n_fail   = 0;
    int tick_div = 1;
    bit done     = 1'b0;
    logic [31:0] mw [0:10];

    always #4 clk = ~clk;

    pwm_gen_bank dut_i (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .dir_pins_o(dir_pins_o),
        .ser_pins_o(ser_pins_o)
    );

    initial begin
        int cnt;
        cnt = 0;
        forever begin
            @(negedge clk);
            tick_en = (cnt == 0);
            cnt = (cnt + 1 >= tick_div) ? 0 : cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit pin(input bit ser, input int idx);
        return ser ? ser_pins_o[idx] : dir_pins_o[idx];
    endfunction

    task automatic write_word(input int addr, input logic [31:0] data);
        wr_en = 1'b1; wr_addr = 4'(addr); wr_data = data;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_period(input int g, input int p);
        mw[g/4][8*(g%4) +: 8] = 8'(p);
        write_word(g/4, mw[g/4]);
    endtask

    task automatic set_duty(input int g, input int h, input int l);
        mw[2+g/2][16*(g%2) +: 16] = {8'(l), 8'(h)};
        write_word(2+g/2, mw[2+g/2]);
    endtask

    task automatic set_map(input bit ser, input int n, input bit en, input int id);
        int w;
        w = (ser ? 8 : 6) + n/8;
        mw[w][4*(n%8) +: 4] = {en, 3'(id)};
        write_word(w, mw[w]);
    endtask

    task automatic run_len(input bit ser, input int idx, input bit lvl, output int n);
        n = 0;
        while (pin(ser, idx) == lvl && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_rise(input bit ser, input int idx);
        bit prev;
        int g;
        prev = pin(ser, idx);
        g = 0;
        @(negedge clk);
        while (!(!prev && pin(ser, idx)) && g < 5000) begin
            prev = pin(ser, idx);
            g++;
            @(negedge clk);
        end
    endtask

    task automatic measure(input bit ser, input int idx, output int hi, output int lo);
        wait_rise(ser, idx);
        run_len(ser, idx, 1'b1, hi);
        run_len(ser, idx, 1'b0, lo);
    endtask

    task automatic count_level(input bit ser, input int idx, input bit lvl, input int n, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            if (pin(ser, idx) == lvl) hits++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        int hits;
        check(dir_pins_o == '0, "R1 direct pins after reset", int'(dir_pins_o), 0);
        check(ser_pins_o == '0, "R1 serial pins after reset", int'(ser_pins_o), 0);
        set_map(1'b0, 0, 1'b1, 0);
        count_level(1'b0, 0, 1'b1, 50, hits);
        check(hits == 0, "R1 cleared generator keeps pin low", hits, 0);
    endtask

    task automatic t_basic;
        int hi, lo;
        set_duty(0, 3, 5);
        set_period(0, 2);
        for (int k = 0; k < 2; k++) begin
            measure(1'b0, 0, hi, lo);
            check(hi == 6, "R5 high run gen0", hi, 6);
            check(lo == 10, "R5 low run gen0", lo, 10);
        end
    endtask

    task automatic t_gen5_serial;
        int hi, lo;
        set_duty(5, 7, 1);
        set_period(5, 1);
        set_map(1'b1, 9, 1'b1, 5);
        measure(1'b1, 9, hi, lo);
        check(hi == 7, "R2 R3 R4 gen5 high on serial pin 9", hi, 7);
        check(lo == 1, "R2 R3 R4 gen5 low on serial pin 9", lo, 1);
    endtask

    task automatic t_slow_tick;
        int hi, lo;
        tick_div = 3;
        repeat (40) @(negedge clk);
        measure(1'b0, 0, hi, lo);
        check(hi == 18, "R5 high run with tick every 3 clocks", hi, 18);
        check(lo == 30, "R5 low run with tick every 3 clocks", lo, 30);
        tick_div = 1;
        repeat (40) @(negedge clk);
    endtask

    task automatic t_full_zero;
        int hits;
        set_duty(2, 255, 0);
        set_period(2, 1);
        set_map(1'b0, 12, 1'b1, 2);
        set_duty(3, 0, 255);
        set_period(3, 1);
        set_map(1'b0, 13, 1'b1, 3);
        repeat (3) @(negedge clk);
        count_level(1'b0, 12, 1'b0, 600, hits);
        check(hits == 0, "R6 full duty never drops", hits, 0);
        count_level(1'b0, 13, 1'b1, 600, hits);
        check(hits == 0, "R7 zero high count never rises", hits, 0);
    endtask

    task automatic t_share;
        set_map(1'b0, 1, 1'b1, 2);
        set_map(1'b0, 2, 1'b0, 2);
        set_map(1'b1, 16, 1'b1, 2);
        check(pin(1'b0, 1) == 1'b1, "R10 enabled pin 1 follows gen2", int'(pin(1'b0, 1)), 1);
        check(pin(1'b0, 2) == 1'b0, "R10 disabled pin 2 low", int'(pin(1'b0, 2)), 0);
        check(pin(1'b1, 16) == 1'b1, "R10 R4 serial pin 16 shares gen2", int'(pin(1'b1, 16)), 1);
        set_map(1'b0, 2, 1'b1, 2);
        check(pin(1'b0, 2) == 1'b1, "R12 enable acts next clock", int'(pin(1'b0, 2)), 1);
        set_map(1'b0, 1, 1'b0, 2);
        check(pin(1'b0, 1) == 1'b0, "R12 disable acts next clock", int'(pin(1'b0, 1)), 0);
    endtask

    task automatic t_stop;
        int hits, hi, lo;
        set_period(0, 0);
        repeat (40) @(negedge clk);
        count_level(1'b0, 0, 1'b1, 100, hits);
        check(hits == 0, "R8 stopped generator low", hits, 0);
        set_duty(0, 2, 3);
        set_period(0, 3);
        check(pin(1'b0, 0) == 1'b0, "R8 still stopped in write clock", int'(pin(1'b0, 0)), 0);
        @(negedge clk);
        check(pin(1'b0, 0) == 1'b1, "R8 starts high next clock", int'(pin(1'b0, 0)), 1);
        run_len(1'b0, 0, 1'b1, hi);
        run_len(1'b0, 0, 1'b0, lo);
        check(hi == 6, "R8 first high run after start", hi, 6);
        check(lo == 9, "R8 first low run after start", lo, 9);
    endtask

    task automatic t_reconfig;
        int hi, lo, hi2, lo2;
        set_duty(0, 4, 4);
        set_period(0, 1);
        repeat (60) @(negedge clk);
        measure(1'b0, 0, hi, lo);
        check(hi == 4 && lo == 4, "R5 gen0 4/4 before change", hi * 100 + lo, 404);
        wait_rise(1'b0, 0);
        hi = 1;
        set_duty(0, 2, 6);
        while (pin(1'b0, 0) && hi < 5000) begin
            hi++;
            @(negedge clk);
        end
        run_len(1'b0, 0, 1'b0, lo);
        run_len(1'b0, 0, 1'b1, hi2);
        run_len(1'b0, 0, 1'b0, lo2);
        check(hi == 4, "R9 running high phase keeps old count", hi, 4);
        check(lo == 4, "R9 running low phase keeps old count", lo, 4);
        check(hi2 == 2, "R9 new high count after boundary", hi2, 2);
        check(lo2 == 6, "R9 new low count after boundary", lo2, 6);
    endtask

    task automatic t_unmapped;
        int hi, lo;
        for (int a = 11; a < 16; a++) write_word(a, 32'hFFFF_FFFF);
        measure(1'b0, 0, hi, lo);
        check(hi == 2, "R11 gen0 high unchanged", hi, 2);
        check(lo == 6, "R11 gen0 low unchanged", lo, 6);
        check(pin(1'b0, 14) == 1'b0, "R11 unmapped direct pin 14 low", int'(pin(1'b0, 14)), 0);
        check(pin(1'b1, 0) == 1'b0, "R11 unmapped serial pin 0 low", int'(pin(1'b1, 0)), 0);
        check(pin(1'b0, 12) == 1'b1, "R11 gen2 still full on", int'(pin(1'b0, 12)), 1);
    endtask

    initial begin
        for (int i = 0; i <= 10; i++) mw[i] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_gen5_serial();
        t_slow_tick();
        t_full_zero();
        t_share();
        t_stop();
        t_reconfig();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule